// File: doc/BRIEF.md
# Two-Bit Equation-Defined Mealy Machine

This block is a small synchronous state machine that watches one serial input bit and produces one output bit. Its memory is a pair of state bits, called A and B here, held in two D flip-flops on a common clock. On every rising edge the pair is reloaded from fixed Boolean next-state equations. The output is of Mealy type: it is formed combinationally from the present state and the input applied right now, so it may change during a cycle as soon as the input changes.

A user drives the input once per cycle and samples the output before the next rising edge. An active-high synchronous reset returns the state to 00. Both state bits come out on ports so that surrounding logic, or a bench, can watch the machine's position directly.

Top module: `mealy2_eqn_fsm`

## Requirements
- R1: When rst is 1 at a rising edge of clk, the state (state_a, state_b) is 00 after that edge, whatever the value of x.
- R2: With rst at 0, the value of state_a after an edge equals x AND (state_a OR state_b), taken before that edge.
- R3: With rst at 0, the value of state_b after an edge equals (NOT state_a) AND x, taken before that edge.
- R4: With rst at 0 and x at 0 at an edge, the state after that edge is 00 from every present state.
- R5: The output y equals (NOT x) AND (state_a OR state_b) at all times, and follows a change of x within the same cycle without waiting for a clock edge.
- R6: From state 00 with x at 1 the output is 0 and the next state is 01 (state_a=0, state_b=1).
- R7: With x at 1, state 01 moves to 11, and states 10 and 11 both move to 10.
- R8: In state 00 the output is 0 for both values of x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state is updated on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the state to 00 |
| x | input | 1 | Serial input bit |
| y | output | 1 | Mealy output, combinational on state and x |
| state_a | output | 1 | Present value of state bit A |
| state_b | output | 1 | Present value of state bit B |

## Verification
Reset and an ordinary transition fall in the same cycle whenever rst is high while x is 1 in a state that would otherwise advance (00, 01, 10 or 11 all move somewhere non-zero or stay non-zero under x=1). The bench provokes this by asserting rst in random cycles together with random x, and also directly from state 01 and state 10 with x held at 1. It judges the outcome by requiring the state ports to read 00 after the edge, i.e. reset must win over the equations, while the output seen during that reset cycle still follows the combinational equation on the present state.

// File: rtl/mealy2_pkg.sv
package mealy2_pkg;

    // Two-bit machine state, bit A first.
    typedef struct packed {
        logic a;
        logic b;
    } m2_state_t;

    localparam int M2_STATE_W = $bits(m2_state_t);
    localparam m2_state_t M2_IDLE = '{a: 1'b0, b: 1'b0};

    // Next value of bit A: input high and either state bit set.
    function automatic logic m2_next_a(input m2_state_t s, input logic xin);
        return xin & (s.a | s.b);
    endfunction

    // Next value of bit B: input high while A is clear.
    function automatic logic m2_next_b(input m2_state_t s, input logic xin);
        return xin & ~s.a;
    endfunction

    // Mealy output: input low while the machine is out of state 00.
    function automatic logic m2_out(input m2_state_t s, input logic xin);
        return ~xin & (s.a | s.b);
    endfunction

endpackage

// File: rtl/mealy2_next.sv
module mealy2_next
    import mealy2_pkg::*;
(
    input  m2_state_t cur,
    input  logic      xin,
    output m2_state_t nxt
);
    always_comb begin
        nxt.a = m2_next_a(cur, xin);
        nxt.b = m2_next_b(cur, xin);
    end
endmodule

// File: rtl/mealy2_out.sv
module mealy2_out
    import mealy2_pkg::*;
(
    input  m2_state_t cur,
    input  logic      xin,
    output logic      yout
);
    always_comb begin
        yout = m2_out(cur, xin);
    end
endmodule

// File: rtl/mealy2_state_reg.sv
module mealy2_state_reg
    import mealy2_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  m2_state_t d,
    output m2_state_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= M2_IDLE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/mealy2_eqn_fsm.sv
module mealy2_eqn_fsm
    import mealy2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x,
    output logic y,
    output logic state_a,
    output logic state_b
);
    m2_state_t cur_s;
    m2_state_t nxt_s;

    mealy2_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (nxt_s),
        .q   (cur_s)
    );

    mealy2_next u_next (
        .cur (cur_s),
        .xin (x),
        .nxt (nxt_s)
    );

    mealy2_out u_out (
        .cur  (cur_s),
        .xin  (x),
        .yout (y)
    );

    assign state_a = cur_s.a;
    assign state_b = cur_s.b;
endmodule

// File: rtl/mealy2_eqn_fsm_chk.sv
module mealy2_eqn_fsm_chk (
    input logic clk,
    input logic rst,
    input logic x,
    input logic y,
    input logic state_a,
    input logic state_b
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!state_a && !state_b)); // R1

    AST_NEXT_A: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (state_a == ($past(x) && ($past(state_a) || $past(state_b))))); // R2

    AST_NEXT_B: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (state_b == ($past(x) && !$past(state_a)))); // R3

    AST_ZERO_INPUT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !x |=> (!state_a && !state_b)); // R4

    AST_OUT_LOW_ON_ONE: assert property (@(posedge clk) disable iff (rst)
        x |-> !y); // R5

    AST_IDLE_TO_01: assert property (@(posedge clk) disable iff (rst)
        (!state_a && !state_b && x) |=> (!state_a && state_b)); // R6

    AST_01_TO_11: assert property (@(posedge clk) disable iff (rst)
        (!state_a && state_b && x) |=> (state_a && state_b)); // R7

    AST_A_SET_TO_10: assert property (@(posedge clk) disable iff (rst)
        (state_a && x) |=> (state_a && !state_b)); // R7

    AST_IDLE_OUT_LOW: assert property (@(posedge clk) disable iff (rst)
        (!state_a && !state_b) |-> !y); // R8
endmodule

bind mealy2_eqn_fsm mealy2_eqn_fsm_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .x       (x),
    .y       (y),
    .state_a (state_a),
    .state_b (state_b)
);

// File: tb/mealy2_eqn_fsm_tb.sv
module mealy2_eqn_fsm_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x   = 1'b0;
    logic y, state_a, state_b;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Bench model of the state, kept independently of the design.
    logic ma = 1'b0;
    logic mb = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    mealy2_eqn_fsm dut_i (
        .clk     (clk),
        .rst     (rst),
        .x       (x),
        .y       (y),
        .state_a (state_a),
        .state_b (state_b)
    );

    function automatic logic exp_y(logic a, logic b, logic xi);
        // Output is high only for x=0 in a state other than 00.
        if (xi) return 1'b0;
        return (a || b);
    endfunction

    function automatic logic [1:0] exp_next(logic a, logic b, logic xi, logic r);
        if (r)   return 2'b00;
        if (!xi) return 2'b00;
        case ({a, b})
            2'b00:   return 2'b01;
            2'b01:   return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive away from the edge, check y, clock, check state.
    task automatic step(logic xv, logic rv, string req);
        logic [1:0] nx;
        @(negedge clk);
        x   = xv;
        rst = rv;
        #2;
        check({req, " y(R5)"}, {1'b0, y}, {1'b0, exp_y(ma, mb, xv)});
        nx = exp_next(ma, mb, xv, rv);
        @(posedge clk);
        #2;
        {ma, mb} = nx;
        check({req, " state"}, {state_a, state_b}, nx);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // Reset state
        step(1'b1, 1'b1, "R1 reset");
        step(1'b0, 1'b1, "R1 reset x0");
        // R6: 00 with x=1 -> 01, y=0
        step(1'b1, 1'b0, "R6 idle-to-01");
        // R7: 01 -> 11, then 11 -> 10, 10 -> 10
        step(1'b1, 1'b0, "R7 01-to-11");
        step(1'b1, 1'b0, "R7 11-to-10");
        step(1'b1, 1'b0, "R7 10-to-10");
        // R4: x=0 from 10
        step(1'b0, 1'b0, "R4 10-to-00");
        // R8: idle, x=0 gives y=0
        step(1'b0, 1'b0, "R8 idle x0");
        // R1 collision: reset from 01 with x=1
        step(1'b1, 1'b0, "R6 to-01");
        step(1'b1, 1'b1, "R1 reset wins over 01");
        // R1 collision: reset from 10 with x=1
        step(1'b1, 1'b0, "R6");
        step(1'b1, 1'b0, "R7");
        step(1'b1, 1'b0, "R7");
        step(1'b1, 1'b1, "R1 reset wins over 10");
        // R5: y follows x within one cycle (state 01)
        step(1'b1, 1'b0, "R6");
        @(negedge clk);
        x = 1'b1;
        #2 check("R5 y with x=1", {1'b0, y}, 2'b00);
        x = 1'b0;
        #2 check("R5 y follows x=0", {1'b0, y}, 2'b01);
        x = 1'b1;
        #2 check("R5 y back with x=1", {1'b0, y}, 2'b00);
        @(posedge clk);
        #2;
        {ma, mb} = exp_next(ma, mb, 1'b1, 1'b0);
        check("R7 after in-cycle toggle", {state_a, state_b}, {ma, mb});
        // Random run: R2 R3 R4 R5 R1
        for (int i = 0; i < 2000; i++) begin
            logic xr;
            logic rr;
            xr = 1'($urandom() & 1);
            rr = (($urandom() & 15) == 0);
            step(xr, rr, "R2 R3 random");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule